// File: doc/BRIEF.md
# DDS Host Command Sequencer

This block sits on the host side of a three-wire serial link to a direct digital synthesis slave. It takes one request at a time: reset, sleep, sine, triangle, square, or "set frequency" to one of two frequency registers. For each request it produces the matching 16-bit command frames. The serial clock, the frame-sync strobe and the data line are all generated from the system clock.

For a mode request it sends one frame: a fixed base control word with a mode mask OR-ed in. For a frequency request it turns an integer frequency in hertz into a 28-bit tuning word. This uses a fixed-point steps-per-hertz constant, split into an integer part and a fractional part scaled by 2^24. The fractional product is formed one byte of the frequency at a time, so no intermediate value overflows. The tuning word then goes out as two 14-bit register writes, each behind a two-bit register prefix.

A request is taken with a single-cycle `req_valid` while the block is idle. `busy` covers the whole transfer, and `done` marks its end.

Top module: `dds_cmd_seq`

## Requirements
- R1: After reset `dds_sclk` and `dds_fsync` are high, and `dds_sdata`, `busy` and `done` are low.
- R2: Mode command codes on `req_cmd` send one frame each: 0 gives 0x2108 (reset), 1 gives 0x22C8 (sleep), 2 gives 0x2238 (sine), 3 gives 0x220A (triangle) and 4 gives 0x2268 (square). Each value is 0x2008 OR-ed with that mode's mask.
- R3: Code 5 (set frequency) computes the tuning word TW as the low 28 bits of hz*K_INT plus, for each byte n of hz (n = 0 is the lowest), (byte_n * K_FRAC) >> (24 - 8n).
- R4: A set-frequency request sends exactly two frames. The first carries TW[13:0] and the second carries TW[27:14], both in bits 13:0. Bits 15:14 hold 01 when `req_fsel` = 0 and 10 when `req_fsel` = 1.
- R5: `dds_fsync` falls while `dds_sclk` is high. Sixteen data bits follow, MSB first, each taken by the slave on a falling `dds_sclk` edge. `dds_fsync` rises after the sixteenth rising edge, and `dds_sclk` is high whenever `dds_fsync` is high.
- R6: Each low phase of `dds_sclk` lasts HALF_PER system clocks. `dds_sdata` holds steady for at least one system clock before every falling `dds_sclk` edge.
- R7: Between the two frames of a set-frequency request, `dds_fsync` stays high for exactly 2*HALF_PER system clocks.
- R8: `busy` rises on the clock edge that accepts a request, on the same edge where `dds_fsync` first falls. It falls on the edge where the last frame's `dds_fsync` rises, and `done` is high for exactly that one following cycle.
- R9: A request presented while `busy` is high is ignored: no extra frame is sent and the frame in progress is unchanged.
- R10: Codes 6 and 7 are ignored: `busy` stays low and no frame is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_cmd | input | 3 | Request code (0 reset, 1 sleep, 2 sine, 3 triangle, 4 square, 5 set frequency) |
| req_fsel | input | 1 | Frequency register target for code 5 (0 or 1) |
| req_hz | input | HZ_W (32) | Frequency in hertz for code 5 |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| dds_sclk | output | 1 | Serial clock to the slave, idles high |
| dds_fsync | output | 1 | Frame strobe, low during a frame |
| dds_sdata | output | 1 | Serial data, MSB first |

## Verification
The bench builds the block with HALF_PER = 2 and the default constants K_INT = 5 and K_FRAC = 6185912. With those values a whole two-frame frequency write takes about 140 system clocks. That is short enough to run every mode code, both unused codes, each byte position of the frequency at its maximum, and a sweep of repeated-byte patterns across the whole 32-bit range for both frequency registers. The small half-period also makes the setup margin and the gap length cheap to count cycle by cycle.

// File: rtl/dds_cmd_pkg.sv
// Shared command codes, control-word constants and state encodings for the
// DDS host command sequencer. Assumes 16-bit frames with a 2-bit prefix.
package dds_cmd_pkg;

    typedef enum logic [2:0] {
        CMD_RESET  = 3'd0,
        CMD_SLEEP  = 3'd1,
        CMD_SINE   = 3'd2,
        CMD_TRI    = 3'd3,
        CMD_SQUARE = 3'd4,
        CMD_FREQ   = 3'd5
    } cmd_e;

    localparam logic [15:0] CTRL_BASE   = 16'h2008;
    localparam logic [15:0] MASK_RESET  = 16'h0100;
    localparam logic [15:0] MASK_SLEEP  = 16'h02C0;
    localparam logic [15:0] MASK_SQUARE = 16'h0260;
    localparam logic [15:0] MASK_SINE   = 16'h0230;
    localparam logic [15:0] MASK_TRI    = 16'h0202;

    localparam logic [1:0] PFX_REG0 = 2'b01;
    localparam logic [1:0] PFX_REG1 = 2'b10;

    typedef enum logic [1:0] {SH_IDLE, SH_LEAD, SH_LOW, SH_HIGH} sh_state_e;
    typedef enum logic [1:0] {SQ_IDLE, SQ_FIRST, SQ_GAP, SQ_SECOND} sq_state_e;

    // Control frame for a mode command code.
    function automatic logic [15:0] mode_word(input logic [2:0] code);
        case (cmd_e'(code))
            CMD_RESET:  return CTRL_BASE | MASK_RESET;
            CMD_SLEEP:  return CTRL_BASE | MASK_SLEEP;
            CMD_SINE:   return CTRL_BASE | MASK_SINE;
            CMD_TRI:    return CTRL_BASE | MASK_TRI;
            CMD_SQUARE: return CTRL_BASE | MASK_SQUARE;
            default:    return CTRL_BASE;
        endcase
    endfunction

endpackage

// File: rtl/dds_tuning_calc.sv
// Combinational tuning-word calculator: TW = hz*K_INT + sum over bytes of
// (byte_n * K_FRAC) >> (FRAC_SH - 8n). Assumes HZ_W = 32, FRAC_SH = 24 and
// K_FRAC < 2^24, so each byte product stays within PROD_W bits.
module dds_tuning_calc #(
    parameter int HZ_W    = 32,
    parameter int TW_W    = 28,
    parameter int K_INT   = 5,
    parameter int K_FRAC  = 6185912,
    parameter int FRAC_SH = 24
) (
    input  logic [HZ_W-1:0] hz,
    output logic [TW_W-1:0] tw
);
    localparam int NBYTES = HZ_W / 8;
    localparam int PROD_W = HZ_W + 8;

    logic [TW_W-1:0] part [NBYTES];
    logic [TW_W-1:0] int_term;

    assign int_term = TW_W'(PROD_W'(hz) * PROD_W'(K_INT));

    for (genvar n = 0; n < NBYTES; n++) begin : g_byte
        assign part[n] = TW_W'((PROD_W'(hz[8*n +: 8]) * PROD_W'(K_FRAC)) >> (FRAC_SH - 8*n));
    end

    // Sum the integer term and the per-byte fractional terms modulo 2^TW_W.
    always_comb begin
        tw = int_term;
        for (int n = 0; n < NBYTES; n++) begin
            tw = tw + part[n];
        end
    end

endmodule

// File: rtl/dds_frame_shifter.sv
// Serialises one FRAME_W-bit word MSB first. SCLK idles high and FSYNC
// falls for a lead phase of HALF_PER clocks with the MSB already on the data
// line. Each bit is a low phase and then a high phase of HALF_PER clocks.
// Data moves only on a rising SCLK, so it is stable for HALF_PER clocks
// before each falling edge. Assumes HALF_PER >= 1 and start only while idle.
module dds_frame_shifter
    import dds_cmd_pkg::*;
#(
    parameter int FRAME_W  = 16,
    parameter int HALF_PER = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] word,
    output logic               last,
    output logic               sclk,
    output logic               fsync,
    output logic               sdata
);
    localparam int PH_W = (HALF_PER > 1) ? $clog2(HALF_PER) : 1;
    localparam int BC_W = $clog2(FRAME_W);

    sh_state_e          st;
    logic [PH_W-1:0]    ph;
    logic [BC_W-1:0]    bit_idx;
    logic [FRAME_W-1:0] shreg;
    logic               ph_end;

    assign ph_end = (ph == PH_W'(HALF_PER - 1));
    assign last   = (st == SH_HIGH) && ph_end && (bit_idx == BC_W'(FRAME_W - 1));
    assign sclk   = (st != SH_LOW);
    assign fsync  = (st == SH_IDLE);
    assign sdata  = shreg[FRAME_W-1];

    // Phase timing, bit counting and shifting for one frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= SH_IDLE;
            ph      <= '0;
            bit_idx <= '0;
            shreg   <= '0;
        end else begin
            case (st)
                SH_IDLE: begin
                    if (start) begin
                        st      <= SH_LEAD;
                        ph      <= '0;
                        bit_idx <= '0;
                        shreg   <= word;
                    end
                end
                SH_LEAD: begin
                    if (ph_end) begin
                        st <= SH_LOW;
                        ph <= '0;
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                SH_LOW: begin
                    if (ph_end) begin
                        st    <= SH_HIGH;
                        ph    <= '0;
                        shreg <= {shreg[FRAME_W-2:0], 1'b0};
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                default: begin
                    if (ph_end) begin
                        ph <= '0;
                        if (bit_idx == BC_W'(FRAME_W - 1)) begin
                            st    <= SH_IDLE;
                            shreg <= '0;
                        end else begin
                            st      <= SH_LOW;
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/dds_cmd_seq.sv
// Top of the DDS host command sequencer. It accepts one request while idle
// and builds the first frame in the accepting cycle. For a frequency request
// it keeps the second frame and sends it after a high gap of one SCLK period.
// Codes above the set-frequency code are dropped. Requests while busy are
// ignored.
module dds_cmd_seq
    import dds_cmd_pkg::*;
#(
    parameter int HZ_W     = 32,
    parameter int HALF_PER = 4,
    parameter int K_INT    = 5,
    parameter int K_FRAC   = 6185912
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      req_cmd,
    input  logic            req_fsel,
    input  logic [HZ_W-1:0] req_hz,
    output logic            busy,
    output logic            done,
    output logic            dds_sclk,
    output logic            dds_fsync,
    output logic            dds_sdata
);
    localparam int FRAME_W = 16;
    localparam int PAY_W   = FRAME_W - 2;
    localparam int TW_W    = 2 * PAY_W;
    localparam int GAP_LEN = 2 * HALF_PER;
    localparam int GC_W    = (GAP_LEN > 1) ? $clog2(GAP_LEN) : 1;

    sq_state_e          st;
    logic [GC_W-1:0]    gap_cnt;
    logic [FRAME_W-1:0] hi_word;
    logic               is_freq;
    logic               done_q;

    logic [TW_W-1:0]    tw;
    logic [1:0]         pfx;
    logic               cmd_ok;
    logic               accept;
    logic               gap_end;
    logic               sh_start;
    logic               sh_last;
    logic [FRAME_W-1:0] first_word;
    logic [FRAME_W-1:0] sh_word;

    dds_tuning_calc #(
        .HZ_W   (HZ_W),
        .TW_W   (TW_W),
        .K_INT  (K_INT),
        .K_FRAC (K_FRAC),
        .FRAC_SH(24)
    ) calc_i (
        .hz(req_hz),
        .tw(tw)
    );

    assign pfx        = req_fsel ? PFX_REG1 : PFX_REG0;
    assign cmd_ok     = (req_cmd <= CMD_FREQ);
    assign accept     = (st == SQ_IDLE) && req_valid && cmd_ok;
    assign gap_end    = (gap_cnt == GC_W'(GAP_LEN - 1));
    assign first_word = (req_cmd == CMD_FREQ) ? {pfx, tw[PAY_W-1:0]} : mode_word(req_cmd);
    assign sh_start   = accept || ((st == SQ_GAP) && gap_end);
    assign sh_word    = (st == SQ_GAP) ? hi_word : first_word;
    assign busy       = (st != SQ_IDLE);
    assign done       = done_q;

    dds_frame_shifter #(
        .FRAME_W (FRAME_W),
        .HALF_PER(HALF_PER)
    ) shift_i (
        .clk  (clk),
        .rst_n(rst_n),
        .start(sh_start),
        .word (sh_word),
        .last (sh_last),
        .sclk (dds_sclk),
        .fsync(dds_fsync),
        .sdata(dds_sdata)
    );

    // Request sequencing: first frame, optional gap, optional second frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= SQ_IDLE;
            gap_cnt <= '0;
            hi_word <= '0;
            is_freq <= 1'b0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    if (accept) begin
                        st      <= SQ_FIRST;
                        is_freq <= (req_cmd == CMD_FREQ);
                        hi_word <= {pfx, tw[TW_W-1:PAY_W]};
                    end
                end
                SQ_FIRST: begin
                    if (sh_last) begin
                        gap_cnt <= '0;
                        st      <= is_freq ? SQ_GAP : SQ_IDLE;
                    end
                end
                SQ_GAP: begin
                    if (gap_end) begin
                        st <= SQ_SECOND;
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                default: begin
                    if (sh_last) begin
                        st <= SQ_IDLE;
                    end
                end
            endcase
        end
    end

    // One-cycle completion pulse, aligned with the final FSYNC rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= sh_last && (((st == SQ_FIRST) && !is_freq) || (st == SQ_SECOND));
        end
    end

endmodule

// File: rtl/dds_cmd_seq_chk.sv
// Protocol checker for dds_cmd_seq, attached with bind. Watches only ports.
module dds_cmd_seq_chk #(
    parameter int HALF_PER = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [2:0] req_cmd,
    input logic       busy,
    input logic       done,
    input logic       dds_sclk,
    input logic       dds_fsync,
    input logic       dds_sdata
);
    logic [15:0] hi_cnt;

    // Count the cycles FSYNC spends high inside a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (dds_fsync && busy) begin
            hi_cnt <= hi_cnt + 1'b1;
        end else if (!dds_fsync) begin
            hi_cnt <= '0;
        end
    end

    assert_sclk_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dds_fsync |-> dds_sclk);

    assert_fsync_fall_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dds_fsync) |-> dds_sclk);

    assert_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dds_sclk) |-> $stable(dds_sdata));

    assert_gap_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dds_fsync) && hi_cnt != 16'd0) |-> hi_cnt == 16'(2 * HALF_PER));

    assert_frame_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dds_fsync |-> busy);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && dds_fsync));

    assert_busy_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    assert_bad_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_cmd > 3'd5) |=> !busy);

endmodule

bind dds_cmd_seq dds_cmd_seq_chk #(.HALF_PER(HALF_PER)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_cmd  (req_cmd),
    .busy     (busy),
    .done     (done),
    .dds_sclk (dds_sclk),
    .dds_fsync(dds_fsync),
    .dds_sdata(dds_sdata)
);

// File: tb/dds_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module dds_cmd_seq_tb_top;
    localparam int H  = 2;
    localparam int KI = 5;
    localparam int KF = 6185912;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_cmd = '0;
    logic        req_fsel = 1'b0;
    logic [31:0] req_hz = '0;
    logic        busy, done, dds_sclk, dds_fsync, dds_sdata;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dds_cmd_seq #(.HZ_W(32), .HALF_PER(H), .K_INT(KI), .K_FRAC(KF)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_fsel(req_fsel), .req_hz(req_hz), .busy(busy), .done(done),
        .dds_sclk(dds_sclk), .dds_fsync(dds_fsync), .dds_sdata(dds_sdata)
    );

    // Line monitor, sampled on the falling system clock.
    logic [15:0] frames [64];
    int          fbits  [64];
    int          nframes = 0;
    logic [15:0] cap = '0;
    int          nbits = 0;
    int          low_cnt = 0, low_bad = 0, setup_bad = 0;
    int          hi_run = 0, last_gap = 0;
    logic        p_sclk = 1'b1, p_fsync = 1'b1, p_sdata = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_sclk && !dds_sclk && !dds_fsync) begin
                cap = {cap[14:0], dds_sdata};
                nbits++;
                if (dds_sdata !== p_sdata) setup_bad++;
            end
            if (!dds_sclk) low_cnt++;
            if (!p_sclk && dds_sclk) begin
                if (low_cnt != H) low_bad++;
                low_cnt = 0;
            end
            if (!p_fsync && dds_fsync) begin
                if (nframes < 64) begin
                    frames[nframes] = cap;
                    fbits[nframes]  = nbits;
                end
                nframes++;
                nbits  = 0;
                hi_run = 0;
            end
            if (dds_fsync) hi_run++;
            if (p_fsync && !dds_fsync) begin
                last_gap = hi_run;
                hi_run   = 0;
            end
        end
        p_sclk  = dds_sclk;
        p_fsync = dds_fsync;
        p_sdata = dds_sdata;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected tuning word, from the arithmetic stated in R3.
    function automatic logic [27:0] exp_tw(input logic [31:0] hz);
        logic [63:0] acc;
        acc = 64'(hz) * 64'(KI);
        for (int n = 0; n < 4; n++) begin
            acc = acc + ((64'(hz[8*n +: 8]) * 64'(KF)) >> (24 - 8*n));
        end
        return acc[27:0];
    endfunction

    task automatic pulse_req(input logic [2:0] c, input logic fs, input logic [31:0] hz);
        req_cmd   = c;
        req_fsel  = fs;
        req_hz    = hz;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int t;
        t = 0;
        while (!done && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk({req, " done pulse"}, done, 1'b1);
        chk({req, " busy low at done"}, busy, 1'b0);
        chk({req, " fsync high at done"}, dds_fsync, 1'b1);
        @(negedge clk);
        chk({req, " done one cycle"}, done, 1'b0);
    endtask

    task automatic run_mode(input logic [2:0] c, input logic [15:0] exp_word);
        int base;
        base = nframes;
        pulse_req(c, 1'b0, 32'd0);
        chk("R8 busy after accept", busy, 1'b1);
        chk("R8 fsync low after accept", dds_fsync, 1'b0);
        wait_done("R8");
        chk("R2 frame count", nframes - base, 1);
        chk("R2 mode frame", frames[base % 64], exp_word);
        chk("R5 bit count", fbits[base % 64], 16);
    endtask

    task automatic run_freq(input logic fs, input logic [31:0] hz);
        int base;
        logic [27:0] tw;
        logic [1:0]  pf;
        base = nframes;
        tw   = exp_tw(hz);
        pf   = fs ? 2'b10 : 2'b01;
        pulse_req(3'd5, fs, hz);
        chk("R8 busy after accept", busy, 1'b1);
        wait_done("R8");
        chk("R4 frame count", nframes - base, 2);
        chk("R3 R4 low frame", frames[base % 64], {pf, tw[13:0]});
        chk("R3 R4 high frame", frames[(base + 1) % 64], {pf, tw[27:14]});
        chk("R5 bit count second", fbits[(base + 1) % 64], 16);
        chk("R7 gap length", last_gap, 2 * H);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sclk", dds_sclk, 1'b1);
        chk("R1 fsync", dds_fsync, 1'b1);
        chk("R1 sdata", dds_sdata, 1'b0);
        chk("R1 busy", busy, 1'b0);
        chk("R1 done", done, 1'b0);

        // R2: every mode code.
        run_mode(3'd0, 16'h2108);
        run_mode(3'd1, 16'h22C8);
        run_mode(3'd2, 16'h2238);
        run_mode(3'd3, 16'h220A);
        run_mode(3'd4, 16'h2268);

        // R10: unused codes.
        for (int c = 6; c < 8; c++) begin
            base = nframes;
            pulse_req(3'(c), 1'b0, 32'hFFFF_FFFF);
            chk("R10 busy stays low", busy, 1'b0);
            repeat (40) @(negedge clk);
            chk("R10 no frame", nframes - base, 0);
            chk("R10 fsync high", dds_fsync, 1'b1);
        end

        // R3/R4: frequency boundary values and both registers.
        run_freq(1'b0, 32'd0);
        run_freq(1'b1, 32'd1);
        run_freq(1'b0, 32'd1_000_000);
        run_freq(1'b1, 32'd25_000_000);
        run_freq(1'b0, 32'hFFFF_FFFF);
        for (int n = 0; n < 4; n++) begin
            run_freq(n[0], 32'hFF << (8 * n));
        end
        for (int b = 0; b < 256; b += 17) begin
            run_freq(b[0], {4{8'(b)}});
        end

        // R9: a request while busy is dropped.
        base = nframes;
        pulse_req(3'd2, 1'b0, 32'd0);
        repeat (10) @(negedge clk);
        pulse_req(3'd5, 1'b1, 32'd12345);
        wait_done("R9");
        repeat (200) @(negedge clk);
        chk("R9 frame count", nframes - base, 1);
        chk("R9 frame kept", frames[base % 64], 16'h2238);
        chk("R9 idle after", busy, 1'b0);

        // R6: phase length and setup margin over the whole run.
        chk("R6 low phase length", low_bad, 0);
        chk("R6 data setup", setup_bad, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule